// File: doc/BRIEF.md
# Video Processor CPU Register Port

This block is the processor-facing register port of a tile-based video processor. A host CPU reaches it through a chip select, an address, separate read and write strobes and an 8-bit data bus. The block keeps only the low three address bits, so its eight register slots repeat every eight bytes across the whole select window. It holds the write-only control and mask settings. It returns a status byte that carries the vertical-blank, sprite-zero-hit and sprite-overflow flags.

The block keeps a 14-bit video memory pointer. Software loads it with two writes to the address slot and reaches memory through the data slot. Each data-slot access produces a one-cycle memory request at the current pointer, and the pointer then advances by 1 or by a row stride, as a control bit selects. An interrupt output follows the vertical-blank flag and is gated by an enable bit. The scroll and address slots share a first/second write toggle, and a status read resets that toggle.

Top module: `vpu_cpu_port`

## Requirements
- R1: Only `cpuAddr[2:0]` selects the register slot. Any address with the same low three bits acts identically: 0 control, 1 mask, 2 status, 3 and 4 unused, 5 scroll, 6 address, 7 data.
- R2: After reset the following are all zero: the control fields, the mask, the vertical-blank flag, the write toggle, the pointer, the scroll values and the memory requests. `ntBase` then reads 0x2000.
- R3: A control write sets the outputs from its data bits. Bits [1:0] give `ntBase` = 0x2000 + 0x400 × value. Bit 3 sets `sprBase` and bit 4 sets `bgBase`: 0 gives 0x0000, 1 gives 0x1000. Bit 5 drives `tallSprites`. Bit 2 selects the pointer step and bit 7 enables the interrupt. Bit 6 has no effect.
- R4: A mask write copies all eight data bits to `maskBits` on the next cycle.
- R5: A status read returns the vertical-blank flag in bit 7, `sprZeroHit` in bit 6 and `sprOverflow` in bit 5, with bits 4..0 zero, in the same cycle.
- R6: A status read clears the vertical-blank flag and the shared write toggle from the next cycle on. A `vblankStart` pulse in that same cycle wins and leaves the flag set.
- R7: On the first address-slot write the pointer's high six bits are taken from data bits [5:0]. The second write supplies the low eight bits and loads the whole pointer.
- R8: Scroll-slot writes alternate on the shared toggle. The first write goes to `scrollX` and the second to `scrollY`.
- R9: A data-slot read or write raises `vramRdReq` or `vramWrReq` for exactly the next cycle. `vramAddr` then holds the pointer value before the step, and a write also latches `vramWdata`. The pointer then steps by 1 when control bit 2 is 0 and by 32 when it is 1, wrapping modulo 2^14.
- R10: A data-slot read returns `vramRdata` on `cpuRdata` in the same cycle.
- R11: `irqOut` is high exactly while both the vertical-blank flag and control bit 7 are set. Setting bit 7 during vertical blank raises it on the next cycle. `vblankStart` sets the flag and `vblankEnd` clears it.
- R12: `cpuRdata` is zero whenever no read is selected, and also on reads of slots other than 2 and 7. Writes to slots 3 and 4 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuSel | input | 1 | Chip select for the register window |
| cpuAddr | input | ADDR_W | CPU address; only bits [2:0] are used |
| cpuRd | input | 1 | Read strobe |
| cpuWr | input | 1 | Write strobe |
| cpuWdata | input | 8 | Write data |
| cpuRdata | output | 8 | Read data (combinational) |
| vblankStart | input | 1 | One-cycle pulse at the start of vertical blank |
| vblankEnd | input | 1 | One-cycle pulse at the end of vertical blank |
| sprZeroHit | input | 1 | Sprite-zero hit flag from the renderer |
| sprOverflow | input | 1 | Sprite overflow flag from the renderer |
| vramRdata | input | 8 | Data returned from video memory |
| vramAddr | output | VRAM_AW | Address of the current memory request |
| vramRdReq | output | 1 | One-cycle video memory read request |
| vramWrReq | output | 1 | One-cycle video memory write request |
| vramWdata | output | 8 | Data for the memory write |
| irqOut | output | 1 | Vertical-blank interrupt |
| ntBase | output | VRAM_AW | Selected nametable base address |
| bgBase | output | VRAM_AW | Background pattern table base |
| sprBase | output | VRAM_AW | Sprite pattern table base |
| tallSprites | output | 1 | Sprite size select (1 = 8x16) |
| maskBits | output | 8 | Render mask and emphasis bits |
| scrollX | output | 8 | First scroll value |
| scrollY | output | 8 | Second scroll value |

## Verification
The assertions assume that the CPU never raises `cpuRd` and `cpuWr` together, so a data-slot access is either a read or a write, never both. They also assume that `vblankStart` and `vblankEnd` arrive as the timing generator's pulses. Every directed sequence and every cycle of the random phase picks one operation (idle, read or write), which keeps the two strobes exclusive. The random phase keeps addresses inside the mirrored window and makes the blanking pulses rare and independent, so a status read, a blanking edge and an enable change fall into the same cycle only now and then. Those same-cycle collisions are the cases that the vertical-blank priority rule decides.

// File: rtl/vpu_port_pkg.sv
package vpu_port_pkg;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 8;
  localparam int IDX_W    = $clog2(NUM_REGS);

  typedef enum logic [IDX_W-1:0] {
    IDX_CTRL = 3'd0,
    IDX_MASK = 3'd1,
    IDX_STAT = 3'd2,
    IDX_OBJA = 3'd3,
    IDX_OBJD = 3'd4,
    IDX_SCRL = 3'd5,
    IDX_ADDR = 3'd6,
    IDX_DATA = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic              ctrlWr;
    logic              maskWr;
    logic              scrollWr;
    logic              addrWr;
    logic              secondHalf;
    logic              statusRd;
    logic              dataRd;
    logic              dataWr;
    logic [DATA_W-1:0] wdata;
  } port_stb_t;
endpackage

// File: rtl/vpu_port_ctrl.sv
module vpu_port_ctrl
  import vpu_port_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSel,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [DATA_W-1:0] cpuWdata,
  output port_stb_t         stb,
  output reg_idx_e          regIdx,
  output logic              readEn
);
  logic [NUM_REGS-1:0] hit;
  logic                toggle;
  logic                unusedAddrHi;

  // incomplete decode: upper address bits are dropped on purpose
  assign unusedAddrHi = ^cpuAddr[ADDR_W-1:IDX_W];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign hit[i] = cpuSel && (cpuAddr[IDX_W-1:0] == IDX_W'(i));
  end

  assign regIdx = reg_idx_e'(cpuAddr[IDX_W-1:0]);
  assign readEn = cpuSel && cpuRd;

  always_comb begin
    stb            = '0;
    stb.ctrlWr     = hit[IDX_CTRL] && cpuWr;
    stb.maskWr     = hit[IDX_MASK] && cpuWr;
    stb.scrollWr   = hit[IDX_SCRL] && cpuWr;
    stb.addrWr     = hit[IDX_ADDR] && cpuWr;
    stb.statusRd   = hit[IDX_STAT] && cpuRd;
    stb.dataRd     = hit[IDX_DATA] && cpuRd;
    stb.dataWr     = hit[IDX_DATA] && cpuWr;
    stb.secondHalf = toggle;
    stb.wdata      = cpuWdata;
  end

  // shared first/second write toggle for scroll and address slots
  always_ff @(posedge clk) begin
    if (!rstN)                         toggle <= 1'b0;
    else if (stb.statusRd)             toggle <= 1'b0;
    else if (stb.scrollWr || stb.addrWr) toggle <= ~toggle;
  end
endmodule

// File: rtl/vpu_port_dp.sv
module vpu_port_dp
  import vpu_port_pkg::*;
#(
  parameter int VRAM_AW  = 14,
  parameter int ROW_STEP = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  port_stb_t          stb,
  input  reg_idx_e           regIdx,
  input  logic               readEn,
  input  logic               vblankStart,
  input  logic               vblankEnd,
  input  logic               sprZeroHit,
  input  logic               sprOverflow,
  input  logic [DATA_W-1:0]  vramRdata,
  output logic [DATA_W-1:0]  cpuRdata,
  output logic [VRAM_AW-1:0] vramAddr,
  output logic               vramRdReq,
  output logic               vramWrReq,
  output logic [DATA_W-1:0]  vramWdata,
  output logic               irqOut,
  output logic [VRAM_AW-1:0] ntBase,
  output logic [VRAM_AW-1:0] bgBase,
  output logic [VRAM_AW-1:0] sprBase,
  output logic               tallSprites,
  output logic [DATA_W-1:0]  maskBits,
  output logic [DATA_W-1:0]  scrollX,
  output logic [DATA_W-1:0]  scrollY,
  output logic [VRAM_AW-1:0] curPtr,
  output logic               irqEnable,
  output logic               stepDown
);
  localparam int HI_W     = VRAM_AW - DATA_W;
  localparam int NT_ORG   = 32'h2000;
  localparam int NT_SPAN  = 32'h0400;
  localparam int PAT_SHFT = 12;

  logic [1:0]         ntSel;
  logic               bgHi, sprHi, vblFlag;
  logic [HI_W-1:0]    hiLatch;
  logic [VRAM_AW-1:0] ptr, stepAmt;

  // control fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEnable   <= 1'b0;
      tallSprites <= 1'b0;
      bgHi        <= 1'b0;
      sprHi       <= 1'b0;
      stepDown    <= 1'b0;
      ntSel       <= 2'b00;
    end else if (stb.ctrlWr) begin
      irqEnable   <= stb.wdata[7];
      tallSprites <= stb.wdata[5];
      bgHi        <= stb.wdata[4];
      sprHi       <= stb.wdata[3];
      stepDown    <= stb.wdata[2];
      ntSel       <= stb.wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           maskBits <= '0;
    else if (stb.maskWr) maskBits <= stb.wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scrollX <= '0;
      scrollY <= '0;
    end else if (stb.scrollWr) begin
      if (stb.secondHalf) scrollY <= stb.wdata;
      else                scrollX <= stb.wdata;
    end
  end

  assign ntBase  = VRAM_AW'(NT_ORG + int'(ntSel) * NT_SPAN);
  assign bgBase  = VRAM_AW'(int'(bgHi) << PAT_SHFT);
  assign sprBase = VRAM_AW'(int'(sprHi) << PAT_SHFT);

  // pointer and memory requests
  assign stepAmt = stepDown ? VRAM_AW'(ROW_STEP) : VRAM_AW'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr     <= '0;
      hiLatch <= '0;
    end else if (stb.addrWr) begin
      if (stb.secondHalf) ptr     <= {hiLatch, stb.wdata};
      else                hiLatch <= stb.wdata[HI_W-1:0];
    end else if (stb.dataRd || stb.dataWr) begin
      ptr <= ptr + stepAmt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vramAddr  <= '0;
      vramRdReq <= 1'b0;
      vramWrReq <= 1'b0;
      vramWdata <= '0;
    end else begin
      vramRdReq <= stb.dataRd;
      vramWrReq <= stb.dataWr;
      if (stb.dataRd || stb.dataWr) vramAddr  <= ptr;
      if (stb.dataWr)               vramWdata <= stb.wdata;
    end
  end

  assign curPtr = ptr;

  // vertical blank flag: the start pulse has priority over clearing
  always_ff @(posedge clk) begin
    if (!rstN)                          vblFlag <= 1'b0;
    else if (vblankStart)               vblFlag <= 1'b1;
    else if (stb.statusRd || vblankEnd) vblFlag <= 1'b0;
  end

  assign irqOut = vblFlag && irqEnable;

  always_comb begin
    cpuRdata = '0;
    if (readEn) begin
      unique case (regIdx)
        IDX_STAT: cpuRdata = {vblFlag, sprZeroHit, sprOverflow, 5'b00000};
        IDX_DATA: cpuRdata = vramRdata;
        default:  cpuRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/vpu_cpu_port.sv
module vpu_cpu_port
  import vpu_port_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int VRAM_AW  = 14,
  parameter int ROW_STEP = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuSel,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic               cpuRd,
  input  logic               cpuWr,
  input  logic [7:0]         cpuWdata,
  output logic [7:0]         cpuRdata,
  input  logic               vblankStart,
  input  logic               vblankEnd,
  input  logic               sprZeroHit,
  input  logic               sprOverflow,
  input  logic [7:0]         vramRdata,
  output logic [VRAM_AW-1:0] vramAddr,
  output logic               vramRdReq,
  output logic               vramWrReq,
  output logic [7:0]         vramWdata,
  output logic               irqOut,
  output logic [VRAM_AW-1:0] ntBase,
  output logic [VRAM_AW-1:0] bgBase,
  output logic [VRAM_AW-1:0] sprBase,
  output logic               tallSprites,
  output logic [7:0]         maskBits,
  output logic [7:0]         scrollX,
  output logic [7:0]         scrollY
);
  port_stb_t          stb;
  reg_idx_e           regIdx;
  logic               readEn;
  logic [VRAM_AW-1:0] curPtr;
  logic               irqEnable;
  logic               stepDown;

  vpu_port_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuAddr(cpuAddr),
    .cpuRd(cpuRd), .cpuWr(cpuWr), .cpuWdata(cpuWdata),
    .stb(stb), .regIdx(regIdx), .readEn(readEn)
  );

  vpu_port_dp #(.VRAM_AW(VRAM_AW), .ROW_STEP(ROW_STEP)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regIdx(regIdx), .readEn(readEn),
    .vblankStart(vblankStart), .vblankEnd(vblankEnd),
    .sprZeroHit(sprZeroHit), .sprOverflow(sprOverflow),
    .vramRdata(vramRdata), .cpuRdata(cpuRdata),
    .vramAddr(vramAddr), .vramRdReq(vramRdReq), .vramWrReq(vramWrReq),
    .vramWdata(vramWdata), .irqOut(irqOut),
    .ntBase(ntBase), .bgBase(bgBase), .sprBase(sprBase),
    .tallSprites(tallSprites), .maskBits(maskBits),
    .scrollX(scrollX), .scrollY(scrollY),
    .curPtr(curPtr), .irqEnable(irqEnable), .stepDown(stepDown)
  );
endmodule

// File: rtl/vpu_port_chk.sv
module vpu_port_chk #(
  parameter int ADDR_W   = 16,
  parameter int VRAM_AW  = 14,
  parameter int ROW_STEP = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               cpuSel,
  input logic [ADDR_W-1:0]  cpuAddr,
  input logic               cpuRd,
  input logic               cpuWr,
  input logic [7:0]         cpuWdata,
  input logic [7:0]         cpuRdata,
  input logic               vblankStart,
  input logic               irqOut,
  input logic               irqEnable,
  input logic               stepDown,
  input logic [VRAM_AW-1:0] curPtr,
  input logic [VRAM_AW-1:0] vramAddr,
  input logic               vramRdReq,
  input logic               vramWrReq,
  input logic [7:0]         vramWdata
);
  logic unusedChkHi;
  logic dataAcc, dataWrite, statRead, ctrlWrite;

  assign unusedChkHi = ^cpuAddr[ADDR_W-1:3];
  assign dataAcc   = cpuSel && (cpuRd || cpuWr) && (cpuAddr[2:0] == 3'd7);
  assign dataWrite = cpuSel && cpuWr && (cpuAddr[2:0] == 3'd7);
  assign statRead  = cpuSel && cpuRd && (cpuAddr[2:0] == 3'd2);
  assign ctrlWrite = cpuSel && cpuWr && (cpuAddr[2:0] == 3'd0);

  AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({vramRdReq, vramWrReq})); // R9

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    dataAcc |=> curPtr == VRAM_AW'($past(curPtr) + ($past(stepDown) ? VRAM_AW'(ROW_STEP) : VRAM_AW'(1)))); // R9

  AST_REQ_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    dataAcc |=> (vramRdReq || vramWrReq) && vramAddr == $past(curPtr)); // R9

  AST_WR_DATA: assert property (@(posedge clk) disable iff (!rstN)
    dataWrite |=> vramWrReq && vramWdata == $past(cpuWdata)); // R9

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> !irqOut); // R11

  AST_VBL_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    vblankStart && irqEnable && !ctrlWrite |=> irqOut); // R11

  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    statRead && !vblankStart |=> !irqOut); // R6

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statRead |-> cpuRdata[4:0] == 5'd0); // R5

  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuSel && cpuRd) |-> cpuRdata == 8'd0); // R12
endmodule

bind vpu_cpu_port vpu_port_chk #(.ADDR_W(ADDR_W), .VRAM_AW(VRAM_AW), .ROW_STEP(ROW_STEP)) u_chk (
  .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuAddr(cpuAddr), .cpuRd(cpuRd),
  .cpuWr(cpuWr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
  .vblankStart(vblankStart), .irqOut(irqOut), .irqEnable(irqEnable),
  .stepDown(stepDown), .curPtr(curPtr), .vramAddr(vramAddr),
  .vramRdReq(vramRdReq), .vramWrReq(vramWrReq), .vramWdata(vramWdata)
);

// File: tb/vpu_cpu_port_tb.sv
module vpu_cpu_port_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuSel = 1'b0, cpuRd = 1'b0, cpuWr = 1'b0;
  logic [15:0] cpuAddr = 16'h2000;
  logic [7:0]  cpuWdata = 8'h00, vramRdata = 8'h00;
  logic        vblankStart = 1'b0, vblankEnd = 1'b0;
  logic        sprZeroHit = 1'b0, sprOverflow = 1'b0;
  logic [7:0]  cpuRdata, vramWdata, maskBits, scrollX, scrollY;
  logic [13:0] vramAddr, ntBase, bgBase, sprBase;
  logic        vramRdReq, vramWrReq, irqOut, tallSprites;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  vpu_cpu_port u_dut (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuAddr(cpuAddr), .cpuRd(cpuRd),
    .cpuWr(cpuWr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .vblankStart(vblankStart), .vblankEnd(vblankEnd),
    .sprZeroHit(sprZeroHit), .sprOverflow(sprOverflow), .vramRdata(vramRdata),
    .vramAddr(vramAddr), .vramRdReq(vramRdReq), .vramWrReq(vramWrReq),
    .vramWdata(vramWdata), .irqOut(irqOut), .ntBase(ntBase), .bgBase(bgBase),
    .sprBase(sprBase), .tallSprites(tallSprites), .maskBits(maskBits),
    .scrollX(scrollX), .scrollY(scrollY)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit       mIrqEn, mTall, mBg, mSpr, mDown, mVbl, mTog, mRq, mWq;
  int       mNt, mMask, mPtr, mHi, mSx, mSy, mRaddr, mWd;

  always @(posedge clk) begin
    int  idx;
    bit  w, r;
    int  expRd;
    string rdReq;
    if (!rstN) begin
      {mIrqEn, mTall, mBg, mSpr, mDown, mVbl, mTog, mRq, mWq} = '0;
      mNt = 0; mMask = 0; mPtr = 0; mHi = 0; mSx = 0; mSy = 0; mRaddr = 0; mWd = 0;
    end else begin
      idx = int'(cpuAddr[2:0]);
      w = cpuSel && cpuWr;
      r = cpuSel && cpuRd;
      mRq = r && idx == 7;
      mWq = w && idx == 7;
      if (mRq || mWq) begin
        mRaddr = mPtr;
        if (mWq) mWd = int'(cpuWdata);
        mPtr = (mPtr + (mDown ? 32 : 1)) % 16384;
      end
      if (w && idx == 0) begin
        mIrqEn = cpuWdata[7]; mTall = cpuWdata[5]; mBg = cpuWdata[4];
        mSpr = cpuWdata[3]; mDown = cpuWdata[2]; mNt = int'(cpuWdata[1:0]);
      end
      if (w && idx == 1) mMask = int'(cpuWdata);
      if (w && idx == 5) begin
        if (!mTog) mSx = int'(cpuWdata); else mSy = int'(cpuWdata);
        mTog = !mTog;
      end
      if (w && idx == 6) begin
        if (!mTog) mHi = int'(cpuWdata) & 63; else mPtr = mHi * 256 + int'(cpuWdata);
        mTog = !mTog;
      end
      if (r && idx == 2) begin mVbl = 0; mTog = 0; end
      if (vblankEnd) mVbl = 0;
      if (vblankStart) mVbl = 1;
    end
    #1;
    check(int'(ntBase) == 'h2000 + mNt * 'h400, "R3", "ntBase", int'(ntBase), 'h2000 + mNt * 'h400);
    check(int'(bgBase) == int'(mBg) * 4096, "R3", "bgBase", int'(bgBase), int'(mBg) * 4096);
    check(int'(sprBase) == int'(mSpr) * 4096, "R3", "sprBase", int'(sprBase), int'(mSpr) * 4096);
    check(tallSprites == mTall, "R3", "tallSprites", int'(tallSprites), int'(mTall));
    check(int'(maskBits) == mMask, "R4", "maskBits", int'(maskBits), mMask);
    check(int'(scrollX) == mSx, "R8", "scrollX", int'(scrollX), mSx);
    check(int'(scrollY) == mSy, "R8", "scrollY", int'(scrollY), mSy);
    check(vramRdReq == mRq, "R9", "vramRdReq", int'(vramRdReq), int'(mRq));
    check(vramWrReq == mWq, "R9", "vramWrReq", int'(vramWrReq), int'(mWq));
    check(int'(vramAddr) == mRaddr, "R9", "vramAddr", int'(vramAddr), mRaddr);
    check(int'(vramWdata) == mWd, "R9", "vramWdata", int'(vramWdata), mWd);
    check(irqOut == (mVbl && mIrqEn), "R11", "irqOut", int'(irqOut), int'(mVbl && mIrqEn));
    expRd = 0;
    rdReq = "R12";
    if (cpuSel && cpuRd) begin
      if (cpuAddr[2:0] == 3'd2) begin
        expRd = (int'(mVbl) << 7) | (int'(sprZeroHit) << 6) | (int'(sprOverflow) << 5);
        rdReq = "R5";
      end else if (cpuAddr[2:0] == 3'd7) begin
        expRd = int'(vramRdata);
        rdReq = "R10";
      end
    end
    check(int'(cpuRdata) == expRd, rdReq, "cpuRdata", int'(cpuRdata), expRd);
  end

  task automatic busOp(input logic [15:0] a, input bit rd, input bit wr,
                       input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    cpuSel = 1'b1; cpuAddr = a; cpuRd = rd; cpuWr = wr; cpuWdata = d;
    #1 q = cpuRdata;
    @(negedge clk);
    cpuSel = 1'b0; cpuRd = 1'b0; cpuWr = 1'b0;
  endtask

  task automatic wrReg(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] q;
    busOp(a, 1'b0, 1'b1, d, q);
  endtask

  task automatic rdReg(input logic [15:0] a, output logic [7:0] q);
    busOp(a, 1'b1, 1'b0, 8'h00, q);
  endtask

  task automatic vblPulse();
    @(negedge clk); vblankStart = 1'b1;
    @(negedge clk); vblankStart = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 reset state
    check(irqOut == 1'b0, "R2", "irqOut after reset", int'(irqOut), 0);
    check(ntBase == 14'h2000, "R2", "ntBase after reset", int'(ntBase), 'h2000);
    check(maskBits == 8'h00, "R2", "maskBits after reset", int'(maskBits), 0);
    rdReg(16'h2002, q);
    check(q == 8'h00, "R2", "status after reset", int'(q), 0);

    // R1 mirrored decode
    wrReg(16'h3FF8, 8'h03);
    check(ntBase == 14'h2C00, "R1", "ntBase via 0x3FF8", int'(ntBase), 'h2C00);
    wrReg(16'h2009, 8'h1E);
    check(maskBits == 8'h1E, "R1", "mask via 0x2009", int'(maskBits), 'h1E);
    wrReg(16'h2000, 8'h38);
    check(bgBase == 14'h1000 && sprBase == 14'h1000 && tallSprites, "R3", "ctrl 0x38 fields",
          int'(bgBase), 'h1000);

    // R7 pointer load, R9 request and step
    wrReg(16'h3456, 8'h21);
    wrReg(16'h2006, 8'h08);
    wrReg(16'h2007, 8'h5A);
    check(vramWrReq && vramAddr == 14'h2108, "R7", "write request address", int'(vramAddr), 'h2108);
    check(vramWdata == 8'h5A, "R9", "write data", int'(vramWdata), 'h5A);
    vramRdata = 8'hC3;
    rdReg(16'h3FFF, q);
    check(q == 8'hC3, "R10", "data slot read", int'(q), 'hC3);
    check(vramRdReq && vramAddr == 14'h2109, "R9", "step by 1", int'(vramAddr), 'h2109);
    wrReg(16'h2000, 8'h04);
    rdReg(16'h2007, q);
    rdReg(16'h2007, q);
    check(vramAddr == 14'h212A, "R9", "step by 32", int'(vramAddr), 'h212A);
    wrReg(16'h2006, 8'hFF);
    wrReg(16'h2006, 8'hF0);
    check(vramAddr == 14'h212A, "R7", "load makes no request", int'(vramAddr), 'h212A);
    wrReg(16'h2007, 8'h11);
    check(vramAddr == 14'h3FF0, "R7", "high bits masked to six", int'(vramAddr), 'h3FF0);
    rdReg(16'h2007, q);
    check(vramAddr == 14'h0010, "R9", "wrap at 14 bits", int'(vramAddr), 'h0010);

    // R11 / R6 interrupt and status clear
    wrReg(16'h2000, 8'h00);
    vblPulse();
    check(irqOut == 1'b0, "R11", "irq gated off", int'(irqOut), 0);
    rdReg(16'h2002, q);
    check(q == 8'h80, "R5", "status vblank bit", int'(q), 'h80);
    rdReg(16'h2002, q);
    check(q == 8'h00, "R6", "vblank cleared by read", int'(q), 0);
    vblPulse();
    wrReg(16'h2000, 8'h80);
    check(irqOut == 1'b1, "R11", "enable during vblank", int'(irqOut), 1);
    rdReg(16'h2002, q);
    check(irqOut == 1'b0, "R6", "irq drops after status read", int'(irqOut), 0);
    vblPulse();
    check(irqOut == 1'b1, "R11", "irq at vblank start", int'(irqOut), 1);
    @(negedge clk); vblankEnd = 1'b1;
    @(negedge clk); vblankEnd = 1'b0;
    check(irqOut == 1'b0, "R11", "irq cleared by vblank end", int'(irqOut), 0);

    // R6 toggle reset
    wrReg(16'h2006, 8'h3F);
    rdReg(16'h2002, q);
    wrReg(16'h2006, 8'h12);
    wrReg(16'h2006, 8'h34);
    wrReg(16'h2007, 8'h77);
    check(vramAddr == 14'h1234, "R6", "toggle reset by status read", int'(vramAddr), 'h1234);

    // R8 scroll
    wrReg(16'h2005, 8'h11);
    wrReg(16'h200D, 8'h22);
    check(scrollX == 8'h11 && scrollY == 8'h22, "R8", "scroll pair", int'(scrollY), 'h22);

    // R12 unused slots
    wrReg(16'h2003, 8'h55);
    wrReg(16'h2004, 8'h66);
    check(maskBits == 8'h1E && scrollX == 8'h11, "R12", "unused writes", int'(maskBits), 'h1E);
    rdReg(16'h2004, q);
    check(q == 8'h00, "R12", "unused slot read", int'(q), 0);
    rdReg(16'h2000, q);
    check(q == 8'h00, "R12", "control slot read", int'(q), 0);

    // R5 sprite flags
    sprZeroHit = 1'b1; sprOverflow = 1'b1;
    rdReg(16'h2002, q);
    check(q == 8'h60, "R5", "sprite flags", int'(q), 'h60);

    // random phase compared every cycle by the model
    for (int i = 0; i < 3000; i++) begin
      int op;
      @(negedge clk);
      op = int'($urandom % 3);
      cpuSel      = 1'($urandom % 2);
      cpuRd       = (op == 1);
      cpuWr       = (op == 2);
      cpuAddr     = 16'h2000 | 16'($urandom & 32'h1FFF);
      cpuWdata    = 8'($urandom);
      vramRdata   = 8'($urandom);
      vblankStart = ($urandom % 12) == 0;
      vblankEnd   = ($urandom % 12) == 0;
      sprZeroHit  = 1'($urandom);
      sprOverflow = 1'($urandom);
    end
    @(negedge clk);
    cpuSel = 1'b0; cpuRd = 1'b0; cpuWr = 1'b0;
    vblankStart = 1'b0; vblankEnd = 1'b0;
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule